// File: doc/BRIEF.md
# Serial IRQ Frame Routing Matrix

This block decides which device interrupt appears in each of the sixteen interrupt frame slots of a serial IRQ stream. Each slot has its own 8-bit routing register. The register names a source device by its frame number (0 to 63) and picks either the first or the second interrupt line of that device. The block gathers the sixteen routed levels into one vector that a downstream serializer reads. The serializer itself is not part of this block.

Host configuration logic programs the registers through a simple byte write port. The slot registers sit at sixteen consecutive offsets, starting at a base of 40h, and all other offsets are ignored. Each slot copies the present level of its chosen source onto a registered output, one clock after the source changes. A global enable forces every slot to zero. A flag reports when two active slots route the same interrupt line. Both slots still carry that level.

The datapath has no state machine. It is a bank of configuration registers, sixteen per-slot selectors, each followed by one flop, and a registered pairwise comparator.

Top module: `sirq_route_matrix`

## Requirements
- R1: After reset every routing register holds FFh, `slot_level` is 0 and `share_conflict` is 0, whatever the interrupt inputs are.
- R2: A write to offset 40h+n (n = 0..15) loads slot n, so 40h is slot 0 and 4Fh is slot 15. A write to any other offset, including 3Fh, 50h and the aliases 31h and 51h, changes no slot.
- R3: Register layout: bit 7 selects the line, bit 6 is the device bit, bits 5:0 are the source frame. Bit 7 = 0 routes `irq_first[frame]` and bit 7 = 1 routes `irq_second[frame]`. For example, 01h routes the first line of frame 1 and 81h routes the second line of frame 1.
- R4: A slot whose device bit (bit 6) is 1 drives 0. This includes the reset and disable value FFh, and values such as C1h.
- R5: A slot carries the level of its source, not an edge. The output stays 1 for as long as the source stays 1, and returns to 0 when the source drops.
- R6: A slot whose frame names a device that is absent from the `DEV_PRESENT` mask drives 0. With the default mask, frames 2 and 63 are absent.
- R7: While `sirq_enable` is 0, every slot drives 0. The routing registers keep their values, and routing resumes once the enable returns to 1.
- R8: When two slots with device bit 0 carry the same bit 7 and frame, both slots reflect the source and `share_conflict` is 1. The same frame with different bit 7 values is not a conflict.
- R9: `slot_level` and `share_conflict` are registered. An input or register change becomes visible one clock after the edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the routing registers |
| cfg_wr_addr | input | 8 | Configuration byte offset |
| cfg_wr_data | input | 8 | Byte written to the addressed slot |
| sirq_enable | input | 1 | Global serial IRQ enable |
| irq_first | input | 64 | First interrupt line of each device, indexed by frame |
| irq_second | input | 64 | Second interrupt line of each device, indexed by frame |
| slot_level | output | 16 | Routed level per IRQ slot, bit n = IRQn |
| share_conflict | output | 1 | Two active slots route the same line |

## Verification
The in-RTL assertions check four things on every cycle:
- All registers hold FFh when reset is released.
- An out-of-range write leaves the register bank unchanged.
- Slots with the device bit set, slots naming an absent frame, and slots while the enable is low all stay at zero.
- A conflict is only flagged when at least two slots are programmed away from FFh.

Other behaviours can only be shown by the bench's directed scenarios:
- That the correct line is picked, first versus second.
- That a level is held for several cycles.
- The one-cycle latency.
- That the slots at both ends of the range are mapped exactly.
- That the address aliases are rejected.
- That a shared source drives both slots and sets the flag, while a different-line pairing does not.

// File: rtl/sirq_route_pkg.sv
package sirq_route_pkg;

    // Number of device frames addressable by the 6-bit frame field.
    localparam int FRAME_W    = 6;
    localparam int NUM_FRAMES = 1 << FRAME_W;

    // Layout of one routing byte; bit positions are fixed by the register format.
    typedef struct packed {
        logic               use_second;  // bit 7: 0 = first line, 1 = second line
        logic               dev_remote;  // bit 6: must be 0 to route
        logic [FRAME_W-1:0] frame;       // bits 5:0: source frame number
    } slot_cfg_t;

    localparam logic [7:0] SLOT_OFF = 8'hFF;

endpackage

// File: rtl/sirq_cfg_bank.sv
module sirq_cfg_bank #(
    parameter int NUM_SLOTS = 16,
    parameter int BASE      = 8'h40
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [7:0]                wr_addr,
    input  logic [7:0]                wr_data,
    output logic [NUM_SLOTS-1:0][7:0] cfg_q
);
    import sirq_route_pkg::*;

    localparam int         IDX_W  = $clog2(NUM_SLOTS);
    localparam logic [7:0] BASE_B = 8'(BASE);
    localparam logic [8:0] LIMIT  = 9'(BASE + NUM_SLOTS);

    logic             hit;
    logic [IDX_W-1:0] idx;

    assign hit = wr_en && (wr_addr >= BASE_B) && ({1'b0, wr_addr} < LIMIT);
    assign idx = IDX_W'(wr_addr - BASE_B);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= {NUM_SLOTS{SLOT_OFF}};
        end else if (hit) begin
            cfg_q[idx] <= wr_data;
        end
    end

    // R1: the bank leaves reset with every slot disabled
    a_r1_reset_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_q == {NUM_SLOTS{SLOT_OFF}}));

    // R2: writes outside the slot window leave the bank untouched
    a_r2_out_of_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((wr_addr < BASE_B) || ({1'b0, wr_addr} >= LIMIT))) |=> $stable(cfg_q));

endmodule

// File: rtl/sirq_slot_mux.sv
module sirq_slot_mux #(
    parameter int                                     NUM_FRAMES  = 64,
    parameter logic [sirq_route_pkg::NUM_FRAMES-1:0] DEV_PRESENT = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            slot_cfg,
    input  logic                  sirq_enable,
    input  logic [NUM_FRAMES-1:0] irq_first,
    input  logic [NUM_FRAMES-1:0] irq_second,
    output logic                  level_q
);
    import sirq_route_pkg::*;

    slot_cfg_t cfg;
    logic      line;
    logic      live;

    always_comb begin
        cfg  = slot_cfg_t'(slot_cfg);
        line = cfg.use_second ? irq_second[cfg.frame] : irq_first[cfg.frame];
        live = sirq_enable && !cfg.dev_remote && DEV_PRESENT[cfg.frame] && line;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= live;
        end
    end

    // R4: the device bit set means the slot stays quiet
    a_r4_remote_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(slot_cfg[6]) |-> !level_q);

    // R6: a frame missing from the presence mask never drives the slot
    a_r6_absent_frame_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !DEV_PRESENT[$past(slot_cfg[5:0])] |-> !level_q);

    // R7: global enable low silences the slot on the next cycle
    a_r7_disable_forces_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sirq_enable) |-> !level_q);

endmodule

// File: rtl/sirq_share_detect.sv
module sirq_share_detect #(
    parameter int NUM_SLOTS = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SLOTS-1:0][7:0] cfg,
    output logic                      conflict_q
);
    import sirq_route_pkg::*;

    logic any_pair;

    always_comb begin
        any_pair = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            for (int j = i + 1; j < NUM_SLOTS; j++) begin
                if (!cfg[i][6] && !cfg[j][6] &&
                    ({cfg[i][7], cfg[i][5:0]} == {cfg[j][7], cfg[j][5:0]})) begin
                    any_pair = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conflict_q <= 1'b0;
        end else begin
            conflict_q <= any_pair;
        end
    end

    // R8: a conflict needs slots that have been programmed away from the off code
    a_r8_conflict_needs_programming: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_q |-> ($past(cfg) != {NUM_SLOTS{SLOT_OFF}}));

endmodule

// File: rtl/sirq_route_matrix.sv
module sirq_route_matrix #(
    parameter int                                     NUM_SLOTS   = 16,
    parameter int                                     BASE        = 8'h40,
    parameter logic [sirq_route_pkg::NUM_FRAMES-1:0] DEV_PRESENT = 64'h0000_0000_0060_1EFB
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cfg_wr_en,
    input  logic [7:0]                            cfg_wr_addr,
    input  logic [7:0]                            cfg_wr_data,
    input  logic                                  sirq_enable,
    input  logic [sirq_route_pkg::NUM_FRAMES-1:0] irq_first,
    input  logic [sirq_route_pkg::NUM_FRAMES-1:0] irq_second,
    output logic [NUM_SLOTS-1:0]                  slot_level,
    output logic                                  share_conflict
);
    import sirq_route_pkg::*;

    logic [NUM_SLOTS-1:0][7:0] cfg_q;

    sirq_cfg_bank #(
        .NUM_SLOTS (NUM_SLOTS),
        .BASE      (BASE)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_wr_addr),
        .wr_data (cfg_wr_data),
        .cfg_q   (cfg_q)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        sirq_slot_mux #(
            .NUM_FRAMES  (NUM_FRAMES),
            .DEV_PRESENT (DEV_PRESENT)
        ) u_mux (
            .clk         (clk),
            .rst_n       (rst_n),
            .slot_cfg    (cfg_q[s]),
            .sirq_enable (sirq_enable),
            .irq_first   (irq_first),
            .irq_second  (irq_second),
            .level_q     (slot_level[s])
        );
    end

    sirq_share_detect #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_share (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg_q),
        .conflict_q (share_conflict)
    );

endmodule

// File: tb/sirq_route_matrix_bench.sv
module sirq_route_matrix_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_addr = '0;
    logic [7:0]  cfg_wr_data = '0;
    logic        sirq_enable = 1'b1;
    logic [63:0] irq_first = '0;
    logic [63:0] irq_second = '0;
    logic [15:0] slot_level;
    logic        share_conflict;

    int vectors = 0;
    int misses = 0;
    bit done = 1'b0;

    always #5ns clk = ~clk;

    sirq_route_matrix u_sirq_route_matrix (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_wr_en      (cfg_wr_en),
        .cfg_wr_addr    (cfg_wr_addr),
        .cfg_wr_data    (cfg_wr_data),
        .sirq_enable    (sirq_enable),
        .irq_first      (irq_first),
        .irq_second     (irq_second),
        .slot_level     (slot_level),
        .share_conflict (share_conflict)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_addr = a;
        cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        irq_first  = '1;
        irq_second = '1;
        step(); step();
        chk("R1 levels", 32'(slot_level), 32'h0);
        chk("R1 conflict", 32'(share_conflict), 32'h0);
        irq_first  = '0;
        irq_second = '0;
        step();
    endtask

    task automatic t_route_first();
        irq_first[1] = 1'b1;
        wr(8'h41, 8'h01);
        chk("R9 latency old value", 32'(slot_level), 32'h0);
        step();
        chk("R3 first line frame 1", 32'(slot_level), 32'h0002);
        irq_first[1]  = 1'b0;
        irq_second[1] = 1'b1;
        step();
        chk("R3 first line ignores second", 32'(slot_level), 32'h0);
        irq_second[1] = 1'b0;
        step();
    endtask

    task automatic t_route_second();
        irq_second[1] = 1'b1;
        wr(8'h41, 8'h81);
        step();
        chk("R3 second line frame 1", 32'(slot_level), 32'h0002);
        irq_second[1] = 1'b0;
        step();
        chk("R9 drop after one cycle", 32'(slot_level), 32'h0);
    endtask

    task automatic t_level_hold();
        irq_second[1] = 1'b1;
        for (int k = 0; k < 5; k++) begin
            step();
            chk("R5 level held", 32'(slot_level), 32'h0002);
        end
        irq_second[1] = 1'b0;
        step();
        chk("R5 level released", 32'(slot_level), 32'h0);
    endtask

    task automatic t_off_codes();
        irq_second[1] = 1'b1;
        wr(8'h41, 8'hFF);
        step();
        chk("R4 FFh off", 32'(slot_level), 32'h0);
        wr(8'h41, 8'hC1);
        step();
        chk("R4 device bit set", 32'(slot_level), 32'h0);
        wr(8'h41, 8'h81);
        step();
        chk("R4 re-enabled", 32'(slot_level), 32'h0002);
    endtask

    task automatic t_range();
        wr(8'h51, 8'hFF);
        wr(8'h31, 8'hFF);
        wr(8'h50, 8'h01);
        wr(8'h3F, 8'h01);
        step();
        chk("R2 aliases ignored", 32'(slot_level), 32'h0002);
        irq_first[3] = 1'b1;
        irq_first[4] = 1'b1;
        wr(8'h4F, 8'h03);
        wr(8'h40, 8'h04);
        step();
        chk("R2 slot 15 and slot 0", 32'(slot_level), 32'h8003);
    endtask

    task automatic t_absent();
        irq_first[2]  = 1'b1;
        irq_first[63] = 1'b1;
        wr(8'h42, 8'h02);
        wr(8'h43, 8'h3F);
        step();
        chk("R6 absent frames", 32'(slot_level), 32'h8003);
    endtask

    task automatic t_enable();
        sirq_enable = 1'b0;
        step();
        chk("R7 disabled", 32'(slot_level), 32'h0);
        step();
        chk("R7 still disabled", 32'(slot_level), 32'h0);
        sirq_enable = 1'b1;
        step();
        chk("R7 registers retained", 32'(slot_level), 32'h8003);
    endtask

    task automatic t_share();
        chk("R8 no conflict yet", 32'(share_conflict), 32'h0);
        wr(8'h45, 8'h81);
        chk("R9 conflict latency", 32'(share_conflict), 32'h0);
        step();
        chk("R8 conflict flagged", 32'(share_conflict), 32'h1);
        chk("R8 both slots carry", 32'(slot_level), 32'h8023);
        wr(8'h45, 8'hFF);
        step();
        chk("R8 conflict cleared", 32'(share_conflict), 32'h0);
        wr(8'h46, 8'h01);
        step();
        chk("R8 other line no conflict", 32'(share_conflict), 32'h0);
        chk("R8 other line level", 32'(slot_level), 32'h8003);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_route_first();
        t_route_second();
        t_level_hold();
        t_off_codes();
        t_range();
        t_absent();
        t_enable();
        t_share();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            vectors++;
            misses++;
            $display("FAIL R9 watchdog actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule